// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is an 8-bit up-counter that produces a high-frequency pulse-width-modulated waveform. It counts from zero to all-ones and then wraps. A select field picks a prescale ratio that turns the system clock into timer ticks. The counter advances only on those ticks, so a full PWM period is 256 ticks long.

The duty cycle comes from a compare value written through a one-cycle write strobe. That value goes into a buffer first. It becomes the active compare value only on the tick where the counter wraps, so a write made in the middle of a period cannot disturb the period in progress.

A two-bit mode picks whether the waveform reaches the pin, and with which polarity. A direction enable must also be set before the waveform drives the pin. The block keeps two sticky flags, one for overflow and one for compare match. Each flag has its own clear strobe and an interrupt request gated by an enable.

Top module: `fpwm_timer`

## Requirements
- R1: While rst_ni is low and after it is released, these are zero: cnt_o, wave_o, pin_o, pin_oe_o, both flags and both interrupt requests. The buffered compare value and the active compare value are also zero.
- R2: presc_sel_i values 0 to 6 select division by 1, 8, 32, 64, 128, 256 and 1024, and the value 7 halts the timer. A free-running prescale count starts at 0 after reset and advances every cycle unless the timer is halted. A tick occurs in each cycle where that count modulo the ratio equals the ratio minus 1. cnt_o increments by one on each tick and holds in every other cycle.
- R3: A tick taken while cnt_o is 255 loads 0, so one period is 256 ticks.
- R4: ovf_flag_o is set by the tick on which the counter wraps from 255 to 0. It is visible in the same cycle in which cnt_o first reads 0.
- R5: cmp_flag_o is set by every tick taken while cnt_o equals the active compare value.
- R6: A cmp_wr_i pulse loads cmp_data_i into the buffer. The buffer is copied to the active compare value only on a wrap tick, so a write has no effect on the waveform before the next wrap.
- R7: With com_mode_i = 2 (non-inverting), wave_o is set by the wrap tick and cleared by a match tick. When both fall on the same tick, the set wins. wave_o is therefore high for the active value plus one ticks of each period, and it is always high when the active value is 255.
- R8: With com_mode_i = 3 (inverting), the behaviour is the complement of R7: wave_o is cleared by the wrap tick and set by a match tick, and the clear wins when both fall on the same tick.
- R9: With com_mode_i = 0 or 1, the pin is disconnected: pin_o and pin_oe_o are 0, and wave_o holds its value.
- R10: pin_oe_o is 1 only when pin_dir_i is 1 and com_mode_i is 2 or 3. When pin_oe_o is 1, pin_o follows wave_o; otherwise pin_o is 0.
- R11: Each flag stays set until its clear input is 1 during a clock cycle, and it reads 0 from the next cycle. If the set event and the clear fall in the same cycle, the flag stays set.
- R12: ovf_irq_o equals ovf_flag_o AND ovf_ie_i, and cmp_irq_o equals cmp_flag_o AND cmp_ie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| presc_sel_i | input | 3 | Prescale ratio select (7 halts) |
| cmp_wr_i | input | 1 | Compare buffer write strobe |
| cmp_data_i | input | 8 | Compare value to buffer |
| com_mode_i | input | 2 | Output mode: 0/1 off, 2 non-inverting, 3 inverting |
| pin_dir_i | input | 1 | Pin direction, 1 = output |
| ovf_clr_i | input | 1 | Clear overflow flag |
| cmp_clr_i | input | 1 | Clear compare flag |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| cnt_o | output | 8 | Counter value |
| wave_o | output | 1 | Waveform register |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | 1 | Compare interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a 10-bit prescale count. At division by 1 a full period takes 256 cycles, so complete periods at compare values 0, 64, 200 and 255 fit in short windows. The same build reaches every ratio up to 1024 and the halted setting, and the bench sweeps through all of them. Writes are placed at chosen counter values to exercise the wrap-time copy of the compare buffer. Clears are held across a wrap to exercise the case where a set and a clear arrive in the same cycle.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    COM_OFF    = 2'd0,
    COM_RSVD   = 2'd1,
    COM_NONINV = 2'd2,
    COM_INV    = 2'd3
  } com_mode_e;

  // log2 of the division ratio; select 7 (halt) maps to 0
  function automatic int unsigned presc_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 3;
      3'd2:    return 5;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import fpwm_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             halt;

  assign halt = (sel_i == 3'd7);

  always_comb begin
    mask = PRE_W'((32'd1 << presc_shift(sel_i)) - 32'd1);
  end

  assign tick_o = !halt && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (!halt) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/fpwm_count_unit.sv
module fpwm_count_unit #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_o,
  output logic             wrap_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, buf_q, act_q;

  assign wrap_o  = tick_i && (cnt_q == MAX_V);
  assign match_o = tick_i && (cnt_q == act_q);
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      if (wr_i)   buf_q <= data_i;
      if (wrap_o) act_q <= buf_q;  // double buffer: load only at wrap
    end
  end
endmodule

// File: rtl/fpwm_wave_unit.sv
module fpwm_wave_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  input  logic       match_i,
  input  logic [1:0] com_i,
  input  logic       dir_i,
  output logic       wave_o,
  output logic       pin_o,
  output logic       pin_oe_o
);
  import fpwm_pkg::*;

  com_mode_e mode;
  logic      pwm_on, set_lvl, wave_q;

  assign mode    = com_mode_e'(com_i);
  assign pwm_on  = (mode == COM_NONINV) || (mode == COM_INV);
  assign set_lvl = (mode == COM_NONINV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else if (pwm_on) begin
      if (wrap_i)       wave_q <= set_lvl;   // wrap wins on coincidence
      else if (match_i) wave_q <= !set_lvl;
    end
  end

  assign wave_o   = wave_q;
  assign pin_oe_o = pwm_on && dir_i;
  assign pin_o    = pin_oe_o && wave_q;
endmodule

// File: rtl/fpwm_flag.sv
module fpwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       presc_sel_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic [1:0]       com_mode_i,
  input  logic             pin_dir_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  input  logic             ovf_ie_i,
  input  logic             cmp_ie_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             ovf_irq_o,
  output logic             cmp_irq_o
);
  localparam int unsigned N_FLAGS = 2;

  logic             tick_w, wrap_w, match_w;
  logic [CNT_W-1:0] act_w;
  logic [N_FLAGS-1:0] set_w, clr_w, ie_w, flag_w, irq_w;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .sel_i(presc_sel_i), .tick_o(tick_w)
  );

  fpwm_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick_w), .wr_i(cmp_wr_i), .data_i(cmp_data_i),
    .cnt_o, .act_o(act_w), .wrap_o(wrap_w), .match_o(match_w)
  );

  fpwm_wave_unit u_wave (
    .clk_i, .rst_ni, .wrap_i(wrap_w), .match_i(match_w), .com_i(com_mode_i),
    .dir_i(pin_dir_i), .wave_o, .pin_o, .pin_oe_o
  );

  assign set_w = {match_w, wrap_w};
  assign clr_w = {cmp_clr_i, ovf_clr_i};
  assign ie_w  = {cmp_ie_i, ovf_ie_i};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    fpwm_flag u_flag (
      .clk_i, .rst_ni, .set_i(set_w[g]), .clr_i(clr_w[g]), .ie_i(ie_w[g]),
      .flag_o(flag_w[g]), .irq_o(irq_w[g])
    );
  end

  assign ovf_flag_o = flag_w[0];
  assign cmp_flag_o = flag_w[1];
  assign ovf_irq_o  = irq_w[0];
  assign cmp_irq_o  = irq_w[1];
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_i,
  input logic [1:0]       com_i,
  input logic             pin_dir_i,
  input logic             wave_i,
  input logic             pin_i,
  input logic             pin_oe_i,
  input logic             ovf_flag_i,
  input logic             cmp_flag_i,
  input logic             ovf_clr_i
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != MAX_V) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == MAX_V) |=> cnt_i == '0);
  assert_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == MAX_V) |=> ovf_flag_i);
  assert_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == act_i) |=> cmp_flag_i);
  assert_buffer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_i == MAX_V) |=> $stable(act_i));
  assert_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == MAX_V && com_i == 2'd2) |=> wave_i);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == MAX_V && com_i == 2'd3) |=> !wave_i);
  assert_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_i[1] |-> (!pin_oe_i && !pin_i));
  assert_dir_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_dir_i |-> (!pin_oe_i && !pin_i));
  assert_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(tick_i && cnt_i == MAX_V)) |=> !ovf_flag_i);
endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tick_i(tick_w), .cnt_i(cnt_o), .act_i(act_w),
  .com_i(com_mode_i), .pin_dir_i, .wave_i(wave_o), .pin_i(pin_o),
  .pin_oe_i(pin_oe_o), .ovf_flag_i(ovf_flag_o), .cmp_flag_i(cmp_flag_o),
  .ovf_clr_i
);

// File: tb/sim_fpwm_timer.sv
module sim_fpwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [1:0] com = 2'd0;
  logic       dir = 1'b0;
  logic       ovf_clr = 1'b0, cmp_clr = 1'b0, ovf_ie = 1'b0, cmp_ie = 1'b0;
  logic [7:0] cnt;
  logic       wave, pin, pin_oe, ovf_f, cmp_f, ovf_irq, cmp_irq;

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  fpwm_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .presc_sel_i(sel), .cmp_wr_i(wr),
    .cmp_data_i(wdata), .com_mode_i(com), .pin_dir_i(dir),
    .ovf_clr_i(ovf_clr), .cmp_clr_i(cmp_clr), .ovf_ie_i(ovf_ie),
    .cmp_ie_i(cmp_ie), .cnt_o(cnt), .wave_o(wave), .pin_o(pin),
    .pin_oe_o(pin_oe), .ovf_flag_o(ovf_f), .cmp_flag_o(cmp_f),
    .ovf_irq_o(ovf_irq), .cmp_irq_o(cmp_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // behavioural reference model
  int m_pre, m_cnt, m_buf, m_act;
  bit m_wave, m_ovf, m_cmp;

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd0: return 1;    3'd1: return 8;   3'd2: return 32;  3'd3: return 64;
      3'd4: return 128;  3'd5: return 256; default: return 1024;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_buf = 0; m_act = 0;
      m_wave = 0; m_ovf = 0; m_cmp = 0;
    end else begin
      bit tk, wrp, mt;
      tk = (sel != 3'd7) && ((m_pre % ratio(sel)) == ratio(sel) - 1);
      if (sel != 3'd7) m_pre = (m_pre + 1) % 1024;
      wrp = tk && (m_cnt == 255);
      mt  = tk && (m_cnt == m_act);
      if (com[1]) begin
        if (wrp)     m_wave = !com[0];
        else if (mt) m_wave = com[0];
      end
      m_ovf = wrp ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      m_cmp = mt  ? 1'b1 : (cmp_clr ? 1'b0 : m_cmp);
      if (wrp) m_act = m_buf;
      if (wr)  m_buf = wdata;
      if (tk)  m_cnt = wrp ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_oe;
      exp_oe = dir && com[1];
      chk(cnt == m_cnt[7:0], "R3 count", cnt, m_cnt);
      chk(ovf_f == m_ovf, "R4 ovf flag", ovf_f, m_ovf);
      chk(cmp_f == m_cmp, "R5 cmp flag", cmp_f, m_cmp);
      chk(wave == m_wave, (com == 2'd3) ? "R8 wave" : "R7 wave", wave, m_wave);
      chk(pin_oe == exp_oe, "R10 pin_oe", pin_oe, exp_oe);
      chk(pin == (exp_oe && m_wave), "R10 pin", pin, exp_oe && m_wave);
      chk(ovf_irq == (m_ovf && ovf_ie), "R12 ovf irq", ovf_irq, m_ovf && ovf_ie);
      chk(cmp_irq == (m_cmp && cmp_ie), "R12 cmp irq", cmp_irq, m_cmp && cmp_ie);
    end
  end

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (cnt != v[7:0]);
  endtask

  task automatic write_cmp(input int v);
    wdata = v[7:0]; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // counts cycles with pin high over one full period at ratio 1
  task automatic high_count(output int h);
    h = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pin) h++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog all", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int h, c0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cnt == 0 && !ovf_f && !cmp_f && !pin && !pin_oe && !wave, "R1 in reset", cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt == 1 && !ovf_f && !wave && !pin, "R1 after release", cnt, 1);

    // non-inverting, compare 64
    com = 2'd2; dir = 1'b1;
    write_cmp(64);
    wait_cnt(0); wait_cnt(1);
    high_count(h);
    chk(h == 65, "R7 high ticks cmp=64", h, 65);

    // R6: mid-period write has no effect before the next wrap
    wait_cnt(10);
    write_cmp(200);
    wait_cnt(100);
    chk(pin == 1'b0, "R6 old compare still active", pin, 0);
    wait_cnt(0); wait_cnt(100);
    chk(pin == 1'b1, "R6 new compare after wrap", pin, 1);

    // compare at MAX: always high
    write_cmp(255);
    wait_cnt(0); wait_cnt(1);
    high_count(h);
    chk(h == 256, "R7 cmp=MAX always set", h, 256);

    // compare at zero: one-tick pulse
    write_cmp(0);
    wait_cnt(0); wait_cnt(1);
    high_count(h);
    chk(h == 1, "R7 cmp=0 single tick", h, 1);

    // inverting
    write_cmp(64);
    wait_cnt(0); wait_cnt(1);
    com = 2'd3;
    wait_cnt(0); wait_cnt(1);
    high_count(h);
    chk(h == 256 - 65, "R8 inverted high ticks", h, 191);

    // disconnected and reserved
    com = 2'd0;
    high_count(h);
    chk(h == 0 && !pin_oe, "R9 mode 0 pin", h, 0);
    com = 2'd1;
    high_count(h);
    chk(h == 0 && !pin_oe, "R9 mode 1 pin", h, 0);

    // direction off
    com = 2'd2; dir = 1'b0;
    high_count(h);
    chk(h == 0 && !pin_oe, "R10 direction input", h, 0);
    dir = 1'b1;

    // flags, clears and interrupts
    ovf_ie = 1'b1; cmp_ie = 1'b1;
    wait_cnt(128);
    chk(ovf_f && cmp_f && ovf_irq && cmp_irq, "R12 irq asserted", ovf_irq, 1);
    ovf_clr = 1'b1; cmp_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0; cmp_clr = 1'b0;
    chk(!ovf_f && !cmp_f, "R11 flags cleared", ovf_f, 0);
    chk(!ovf_irq && !cmp_irq, "R12 irq dropped", ovf_irq, 0);
    ovf_ie = 1'b0;
    wait_cnt(250);
    ovf_clr = 1'b1;
    wait_cnt(3);
    chk(ovf_f == 1'b0, "R11 clear holds flag low", ovf_f, 0);
    wait_cnt(255);
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(ovf_f == 1'b1 && !ovf_irq, "R11 set wins over clear", ovf_f, 1);

    // prescaler sweep
    for (int s = 1; s <= 6; s++) begin
      sel = s[2:0];
      repeat (3000) @(negedge clk);
    end
    sel = 3'd6;
    c0 = cnt;
    repeat (2048) @(negedge clk);
    chk(((cnt - c0) & 8'hff) == 2, "R2 ratio 1024 step count", (cnt - c0) & 8'hff, 2);
    sel = 3'd3;
    c0 = cnt;
    repeat (640) @(negedge clk);
    chk(((cnt - c0) & 8'hff) == 10, "R2 ratio 64 step count", (cnt - c0) & 8'hff, 10);
    sel = 3'd7;
    c0 = cnt;
    repeat (500) @(negedge clk);
    chk(cnt == c0[7:0], "R2 halted", cnt, c0);
    sel = 3'd0;
    repeat (600) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule